// File: doc/BRIEF.md
# Multiplexed External Bus Port Controller

This block sits between an internal 16-bit bus master and two 8-bit pin ports, A and B. At reset it takes the operating mode from two mode pins and keeps that mode until the next reset. In single-chip mode both ports are plain bidirectional I/O. The pin values, enables and input readback all come from the general-purpose I/O side. In the two expanded modes the ports form an external bus that is timed by a generated E phase. While E is low the ports carry the address. While E is high they carry data.

In wide mode, port A carries the upper address and data byte and port B carries the lower byte. In narrow mode, port B holds the low address byte for the whole bus cycle. Port A switches from the high address byte to a single data byte. A 16-bit narrow access runs as two byte cycles, high byte first, and the requester is stalled until both bytes are done. An external device is expected to capture the address on the rising edge of E through a transparent latch. For that reason the address is held steady for the whole low phase.

Top module: `ebus_port_ctrl`

## Requirements
- R1: The mode is sampled from `mode_i` on every clock edge while `rst_ni` is low. It is held unchanged after reset is released, whatever `mode_i` does later. Encoding: 2'b01 is narrow, 2'b10 is wide, and 2'b00 and 2'b11 are both single-chip.
- R2: In single-chip mode, `pa_o`/`pa_oe_o` equal `gpa_out_i`/`gpa_oe_i` and `pb_o`/`pb_oe_o` equal `gpb_out_i`/`gpb_oe_i`, and `e_o` stays low. In every mode, `gpa_in_o` and `gpb_in_o` mirror `pa_i` and `pb_i`.
- R3: In single-chip mode, a request sampled at a clock edge gives a one-clock `ack_o` at that edge, with `rdata_o` zero and no effect on the pins.
- R4: In the expanded modes, `e_o` spends PHASE_CYC clocks low and then PHASE_CYC clocks high, starting low after reset. Outside an access, `rw_o` is high and both output enables are low.
- R5: A bus access starts only at the clock edge that ends an E-high phase. `ack_o` is high for exactly one clock, and it rises on the same edge at which E falls at the end of the access's last data phase.
- R6: In wide mode, during E low, `pa_o` = addr[15:8] and `pb_o` = addr[7:0], both fully enabled and stable for the whole phase.
- R7: In wide mode, during E high, a write drives wdata[15:8] on A and wdata[7:0] on B with full enables. A read releases both enables and returns {pa_i, pb_i} as sampled on the last clock of the data phase. `size16_i` has no effect in wide mode.
- R8: In narrow mode, port B drives the low address byte with full enable through the whole bus cycle. Port A drives the high address byte while E is low and one data byte while E is high. On a read, A's enable is released while E is high.
- R9: In narrow mode, a 16-bit access (`size16_i`=1) runs two byte cycles, at {addr[15:1],0} and then {addr[15:1],1}. The first cycle carries data bits 15:8 and the second carries bits 7:0. A read returns {first byte, second byte}.
- R10: In narrow mode, an 8-bit access runs one byte cycle at addr. addr[0]=0 selects lane 15:8 and addr[0]=1 selects lane 7:0. A write drives that lane of wdata on A. A read returns the byte in that lane and zero in the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; mode sampling window |
| mode_i | input | 2 | Mode select pins |
| req_i | input | 1 | Internal access request, held until ack |
| we_i | input | 1 | 1 = write |
| size16_i | input | 1 | 1 = 16-bit access |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with ack |
| ack_o | output | 1 | Access complete pulse |
| gpa_out_i | input | 8 | Port A I/O output value |
| gpa_oe_i | input | 8 | Port A I/O output enable |
| gpb_out_i | input | 8 | Port B I/O output value |
| gpb_oe_i | input | 8 | Port B I/O output enable |
| gpa_in_o | output | 8 | Port A pin readback |
| gpb_in_o | output | 8 | Port B pin readback |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A pin output |
| pa_oe_o | output | 8 | Port A pin output enable |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B pin output |
| pb_oe_o | output | 8 | Port B pin output enable |
| e_o | output | 1 | E bus phase |
| rw_o | output | 1 | 1 = read cycle or idle |

## Verification
An expanded access is accepted on the edge that ends an E-high phase. Its address phase then lasts PHASE_CYC clocks and its data phase another PHASE_CYC. `ack_o` rises on the edge where the last data phase ends, so a narrow 16-bit access acknowledges one E period later than a single-cycle access. In single-chip mode, `ack_o` rises on the edge that samples the request. The bench samples every output at the falling clock edge. It models the external transparent latch on the E-low samples and keeps the last E-high sample of each bus cycle as its data phase. At the first sample showing `ack_o`, it checks that E has just fallen and that the expected number of bus cycles were seen, so each result is compared in the cycle it is due.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    BM_SINGLE = 2'b00,
    BM_NARROW = 2'b01,
    BM_WIDE   = 2'b10
  } bus_mode_e;

  function automatic bus_mode_e decode_mode(input logic [1:0] pins);
    case (pins)
      2'b01:   return BM_NARROW;
      2'b10:   return BM_WIDE;
      default: return BM_SINGLE;
    endcase
  endfunction
endpackage

// File: rtl/ebus_eclk_gen.sv
module ebus_eclk_gen #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic e_o,
  output logic end_high_o
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          e_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      e_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      e_q   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      e_q   <= ~e_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign e_o        = e_q;
  assign end_high_o = en_i && e_q && (cnt_q == LAST);
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_mode_e     mode_i,
  input  logic          end_high_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          size16_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] pa_i,
  input  logic [BW-1:0] pb_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [BW-1:0] cur_byte_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o
);
  logic          busy_q, we_q, size_q, idx_q, ack_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          narrow, wide, split, lane_lo;

  assign narrow  = (mode_i == BM_NARROW);
  assign wide    = (mode_i == BM_WIDE);
  assign split   = narrow && size_q;
  // narrow lane: byte index for split accesses, address LSB otherwise
  assign lane_lo = split ? idx_q : addr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      size_q  <= 1'b0;
      idx_q   <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (mode_i == BM_SINGLE) begin
        busy_q  <= 1'b0;
        rdata_q <= '0;
        ack_q   <= req_i && !ack_q;
      end else if (end_high_i) begin
        if (busy_q) begin
          if (!we_q) begin
            if (wide)         rdata_q <= {pa_i, pb_i};
            else if (lane_lo) rdata_q[BW-1:0] <= pa_i;
            else              rdata_q[DW-1:BW] <= pa_i;
          end
          if (split && !idx_q) begin
            idx_q <= 1'b1;
          end else begin
            busy_q <= 1'b0;
            ack_q  <= 1'b1;
          end
        end else if (req_i) begin
          busy_q  <= 1'b1;
          we_q    <= we_i;
          size_q  <= size16_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          idx_q   <= 1'b0;
          rdata_q <= '0;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign we_o       = we_q;
  assign cur_addr_o = split ? {addr_q[AW-1:1], idx_q} : addr_q;
  assign cur_byte_o = lane_lo ? wdata_q[BW-1:0] : wdata_q[DW-1:BW];
  assign wdata_o    = wdata_q;
  assign rdata_o    = rdata_q;
  assign ack_o      = ack_q;
endmodule

// File: rtl/ebus_pin_mux.sv
module ebus_pin_mux
  import ebus_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW,
  localparam int DW = 2 * BW
) (
  input  bus_mode_e     mode_i,
  input  logic          e_i,
  input  logic          busy_i,
  input  logic          we_i,
  input  logic [AW-1:0] cur_addr_i,
  input  logic [BW-1:0] cur_byte_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] gpa_out_i,
  input  logic [BW-1:0] gpa_oe_i,
  input  logic [BW-1:0] gpb_out_i,
  input  logic [BW-1:0] gpb_oe_i,
  output logic [BW-1:0] pa_o,
  output logic [BW-1:0] pa_oe_o,
  output logic [BW-1:0] pb_o,
  output logic [BW-1:0] pb_oe_o,
  output logic          rw_o
);
  always_comb begin
    pa_o    = '0;
    pa_oe_o = '0;
    pb_o    = '0;
    pb_oe_o = '0;
    rw_o    = 1'b1;
    if (mode_i == BM_SINGLE) begin
      pa_o    = gpa_out_i;
      pa_oe_o = gpa_oe_i;
      pb_o    = gpb_out_i;
      pb_oe_o = gpb_oe_i;
    end else if (busy_i) begin
      rw_o = !we_i;
      if (mode_i == BM_WIDE) begin
        if (!e_i) begin
          pa_o    = cur_addr_i[AW-1:BW];
          pb_o    = cur_addr_i[BW-1:0];
          pa_oe_o = '1;
          pb_oe_o = '1;
        end else if (we_i) begin
          pa_o    = wdata_i[DW-1:BW];
          pb_o    = wdata_i[BW-1:0];
          pa_oe_o = '1;
          pb_oe_o = '1;
        end
      end else begin
        pb_o    = cur_addr_i[BW-1:0];
        pb_oe_o = '1;
        if (!e_i) begin
          pa_o    = cur_addr_i[AW-1:BW];
          pa_oe_o = '1;
        end else if (we_i) begin
          pa_o    = cur_byte_i;
          pa_oe_o = '1;
        end
      end
    end
  end
endmodule

// File: rtl/ebus_port_ctrl.sv
module ebus_port_ctrl
  import ebus_pkg::*;
#(
  parameter int BW = 8,
  parameter int PHASE_CYC = 2,
  localparam int AW = 2 * BW,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          size16_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  input  logic [BW-1:0] gpa_out_i,
  input  logic [BW-1:0] gpa_oe_i,
  input  logic [BW-1:0] gpb_out_i,
  input  logic [BW-1:0] gpb_oe_i,
  output logic [BW-1:0] gpa_in_o,
  output logic [BW-1:0] gpb_in_o,
  input  logic [BW-1:0] pa_i,
  output logic [BW-1:0] pa_o,
  output logic [BW-1:0] pa_oe_o,
  input  logic [BW-1:0] pb_i,
  output logic [BW-1:0] pb_o,
  output logic [BW-1:0] pb_oe_o,
  output logic          e_o,
  output logic          rw_o
);
  bus_mode_e     mode_q;
  logic          end_high, busy, seq_we;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_byte;
  logic [DW-1:0] seq_wdata;

  // mode pins are watched for as long as reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= decode_mode(mode_i);
  end

  ebus_eclk_gen #(.PHASE_CYC(PHASE_CYC)) u_eclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_q != BM_SINGLE),
    .e_o       (e_o),
    .end_high_o(end_high)
  );

  ebus_seq #(.BW(BW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .end_high_i(end_high),
    .req_i     (req_i),
    .we_i      (we_i),
    .size16_i  (size16_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pa_i      (pa_i),
    .pb_i      (pb_i),
    .busy_o    (busy),
    .we_o      (seq_we),
    .cur_addr_o(cur_addr),
    .cur_byte_o(cur_byte),
    .wdata_o   (seq_wdata),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o)
  );

  ebus_pin_mux #(.BW(BW)) u_mux (
    .mode_i    (mode_q),
    .e_i       (e_o),
    .busy_i    (busy),
    .we_i      (seq_we),
    .cur_addr_i(cur_addr),
    .cur_byte_i(cur_byte),
    .wdata_i   (seq_wdata),
    .gpa_out_i (gpa_out_i),
    .gpa_oe_i  (gpa_oe_i),
    .gpb_out_i (gpb_out_i),
    .gpb_oe_i  (gpb_oe_i),
    .pa_o      (pa_o),
    .pa_oe_o   (pa_oe_o),
    .pb_o      (pb_o),
    .pb_oe_o   (pb_oe_o),
    .rw_o      (rw_o)
  );

  assign gpa_in_o = pa_i;
  assign gpb_in_o = pb_i;
endmodule

// File: rtl/ebus_port_ctrl_chk.sv
module ebus_port_ctrl_chk
  import ebus_pkg::*;
#(
  parameter int BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input bus_mode_e     mode_q,
  input logic          busy,
  input logic          e_o,
  input logic          rw_o,
  input logic          ack_o,
  input logic [BW-1:0] pa_o,
  input logic [BW-1:0] pb_o,
  input logic [BW-1:0] pa_oe_o,
  input logic [BW-1:0] pb_oe_o
);
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q)); // R1

  AST_SINGLE_E_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_SINGLE) |-> !e_o); // R2

  AST_ACK_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !e_o && $past(busy && !e_o)) |-> ($stable(pa_o) && $stable(pb_o))); // R6

  AST_WIDE_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_WIDE && busy && e_o && rw_o) |-> (pa_oe_o == '0 && pb_oe_o == '0)); // R7

  AST_NARROW_B_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_NARROW && busy) |-> (pb_oe_o == '1)); // R8

  AST_NARROW_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_NARROW && busy && e_o && rw_o) |-> (pa_oe_o == '0)); // R8
endmodule

bind ebus_port_ctrl ebus_port_ctrl_chk #(.BW(BW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_q (mode_q),
  .busy   (busy),
  .e_o    (e_o),
  .rw_o   (rw_o),
  .ack_o  (ack_o),
  .pa_o   (pa_o),
  .pb_o   (pb_o),
  .pa_oe_o(pa_oe_o),
  .pb_oe_o(pb_oe_o)
);

// File: tb/sim_ebus_port_ctrl.sv
`timescale 1ns/1ps
module sim_ebus_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int PH = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b10;
  logic        req_i = 1'b0, we_i = 1'b0, size16_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0, rdata_o;
  logic        ack_o, e_o, rw_o;
  logic [7:0]  gpa_out_i = '0, gpa_oe_i = '0, gpb_out_i = '0, gpb_oe_i = '0;
  logic [7:0]  gpa_in_o, gpb_in_o, pa_i, pb_i, pa_o, pb_o, pa_oe_o, pb_oe_o;
  logic [7:0]  ext_a = 8'h00, ext_b = 8'h00;
  logic        mem_en = 1'b0, narrow_sel = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ebus_port_ctrl #(.BW(BW), .PHASE_CYC(PH)) u0 (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external transparent address latch and per-cycle record
  logic [15:0] lat_addr = '0;
  logic        e_prev = 1'b0, efall = 1'b0, lo_act = 1'b0;
  logic [7:0]  hi_pa, hi_pb, hi_paoe, hi_pboe;
  int          n_rec = 0;
  logic [15:0] rec_addr [4];
  logic [7:0]  rec_pa [4], rec_pb [4], rec_paoe [4], rec_pboe [4];

  assign pa_i = (mem_en && e_o && rw_o) ?
                (narrow_sel ? memf(lat_addr) : memf({lat_addr[15:1], 1'b0})) : ext_a;
  assign pb_i = (mem_en && e_o && rw_o && !narrow_sel) ? memf({lat_addr[15:1], 1'b1}) : ext_b;

  always @(negedge clk_i) begin
    efall = e_prev && !e_o;
    if (efall && lo_act) begin
      if (n_rec < 4) begin
        rec_addr[n_rec] = lat_addr;
        rec_pa[n_rec]   = hi_pa;
        rec_pb[n_rec]   = hi_pb;
        rec_paoe[n_rec] = hi_paoe;
        rec_pboe[n_rec] = hi_pboe;
      end
      n_rec++;
      lo_act = 1'b0;
    end
    if (!e_o) begin
      lat_addr = {pa_o, pb_o};
      if (pa_oe_o != 8'h00) lo_act = 1'b1;
    end else begin
      hi_pa = pa_o; hi_pb = pb_o; hi_paoe = pa_oe_o; hi_pboe = pb_oe_o;
    end
    e_prev = e_o;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic apply_reset(input logic [1:0] m);
    step();
    rst_ni = 1'b0; mode_i = m; req_i = 1'b0;
    narrow_sel = (m == 2'b01);
    repeat (3) step();
    rst_ni = 1'b1;
    step();
  endtask

  // run one expanded access; returns read data and bus cycle count
  task automatic bus_access(input logic we, input logic sz, input logic [15:0] a,
                            input logic [15:0] wd, output logic [15:0] rd,
                            output int ncyc, output bit ack_ok);
    int guard = 0;
    mem_en = 1'b1;
    n_rec = 0;
    req_i = 1'b1; we_i = we; size16_i = sz; addr_i = a; wdata_i = wd;
    step();
    while (!ack_o && guard < 200) begin step(); guard++; end
    rd = rdata_o;
    ncyc = n_rec;
    ack_ok = ack_o && efall;
    req_i = 1'b0;
    step();
    ack_ok = ack_ok && !ack_o;
    mem_en = 1'b0;
  endtask

  task automatic t_reset_state();
    apply_reset(2'b10);
    chk(e_o == 1'b0, "R4", "e after reset", 32'(e_o), 0);
    chk(rw_o == 1'b1 && pa_oe_o == 0 && pb_oe_o == 0, "R4", "idle pins",
        {rw_o, pa_oe_o, pb_oe_o}, 32'h10000);
    chk(ack_o == 1'b0, "R5", "ack after reset", 32'(ack_o), 0);
  endtask

  task automatic t_e_period();
    int hi = 0, lo = 0;
    while (e_o) step();
    while (!e_o) step();
    while (e_o) begin hi++; step(); end
    while (!e_o) begin lo++; step(); end
    chk(hi == PH && lo == PH, "R4", "E phase lengths", {16'(hi), 16'(lo)}, {16'(PH), 16'(PH)});
  endtask

  task automatic t_wide_write();
    logic [15:0] rd; int nc; bit ak;
    bus_access(1'b1, 1'b1, 16'h3A71, 16'hBEEF, rd, nc, ak);
    chk(nc == 1, "R7", "wide write cycles", nc, 1);
    chk(rec_addr[0] == 16'h3A71, "R6", "wide latched addr", rec_addr[0], 16'h3A71);
    chk({rec_pa[0], rec_pb[0]} == 16'hBEEF, "R7", "wide write data",
        {rec_pa[0], rec_pb[0]}, 16'hBEEF);
    chk(rec_paoe[0] == 8'hFF && rec_pboe[0] == 8'hFF, "R7", "wide write oe",
        {rec_paoe[0], rec_pboe[0]}, 16'hFFFF);
    chk(ak, "R5", "ack one clock on E fall", 32'(ak), 1);
  endtask

  task automatic t_wide_read();
    logic [15:0] rd, exp; int nc; bit ak;
    bus_access(1'b0, 1'b0, 16'h1234, 16'h0, rd, nc, ak);
    exp = {memf(16'h1234), memf(16'h1235)};
    chk(rd == exp, "R7", "wide read data (size ignored)", rd, exp);
    chk(nc == 1 && rec_paoe[0] == 0 && rec_pboe[0] == 0, "R7", "wide read release",
        {nc[7:0], rec_paoe[0], rec_pboe[0]}, 32'h010000);
    chk(ak, "R5", "read ack timing", 32'(ak), 1);
  endtask

  task automatic t_mode_held();
    int rises = 0;
    mode_i = 2'b00;
    repeat (4 * PH + 2) begin
      logic e0 = e_o;
      step();
      if (!e0 && e_o) rises++;
    end
    chk(rises >= 1, "R1", "mode held after reset (E runs)", rises, 1);
    ext_a = 8'hC3; ext_b = 8'h3C; step();
    chk(gpa_in_o == 8'hC3 && gpb_in_o == 8'h3C, "R2", "readback in wide",
        {gpa_in_o, gpb_in_o}, 16'hC33C);
  endtask

  task automatic t_narrow_write16();
    logic [15:0] rd; int nc; bit ak;
    apply_reset(2'b01);
    bus_access(1'b1, 1'b1, 16'h8040, 16'hA55A, rd, nc, ak);
    chk(nc == 2, "R9", "narrow 16 write cycles", nc, 2);
    chk(rec_addr[0] == 16'h8040 && rec_addr[1] == 16'h8041, "R9", "byte cycle addrs",
        {rec_addr[0], rec_addr[1]}, 32'h80408041);
    chk(rec_pa[0] == 8'hA5 && rec_pa[1] == 8'h5A, "R9", "high byte first",
        {rec_pa[0], rec_pa[1]}, 16'hA55A);
    chk(rec_pb[0] == 8'h40 && rec_pb[1] == 8'h41 && rec_pboe[1] == 8'hFF, "R8",
        "B holds addr in data phase", {rec_pb[0], rec_pb[1], rec_pboe[1]}, 24'h4041FF);
    chk(ak, "R5", "narrow ack after second cycle", 32'(ak), 1);
  endtask

  task automatic t_narrow_read16();
    logic [15:0] rd, exp; int nc; bit ak;
    bus_access(1'b0, 1'b1, 16'h2C91, 16'h0, rd, nc, ak);
    exp = {memf(16'h2C90), memf(16'h2C91)};
    chk(rd == exp && nc == 2, "R9", "narrow 16 read", {nc[15:0], rd}, {16'd2, exp});
    chk(rec_paoe[0] == 0 && rec_paoe[1] == 0 && rec_pboe[0] == 8'hFF, "R8",
        "narrow read A released", {rec_paoe[0], rec_paoe[1], rec_pboe[0]}, 24'h0000FF);
  endtask

  task automatic t_narrow_byte();
    logic [15:0] rd, exp; int nc; bit ak;
    bus_access(1'b1, 1'b0, 16'h0107, 16'h9C3E, rd, nc, ak);
    chk(nc == 1 && rec_addr[0] == 16'h0107 && rec_pa[0] == 8'h3E, "R10", "odd byte write",
        {nc[7:0], rec_addr[0], rec_pa[0]}, 32'h0101073E);
    bus_access(1'b1, 1'b0, 16'h0106, 16'h9C3E, rd, nc, ak);
    chk(nc == 1 && rec_pa[0] == 8'h9C, "R10", "even byte write",
        {nc[7:0], rec_pa[0]}, 16'h019C);
    bus_access(1'b0, 1'b0, 16'h4455, 16'h0, rd, nc, ak);
    exp = {8'h00, memf(16'h4455)};
    chk(rd == exp && nc == 1, "R10", "odd byte read lane", rd, exp);
    bus_access(1'b0, 1'b0, 16'h4454, 16'h0, rd, nc, ak);
    exp = {memf(16'h4454), 8'h00};
    chk(rd == exp && ak, "R10", "even byte read lane", rd, exp);
  endtask

  task automatic t_single();
    apply_reset(2'b11);
    gpa_out_i = 8'h5E; gpa_oe_i = 8'hF0; gpb_out_i = 8'h21; gpb_oe_i = 8'h0F;
    ext_a = 8'h77; ext_b = 8'h88;
    repeat (2 * PH + 1) begin
      step();
      if (e_o) chk(1'b0, "R2", "E toggled in single-chip", 32'(e_o), 0);
    end
    chk(pa_o == 8'h5E && pa_oe_o == 8'hF0 && pb_o == 8'h21 && pb_oe_o == 8'h0F, "R2",
        "gpio passthrough", {pa_o, pa_oe_o, pb_o, pb_oe_o}, 32'h5EF0210F);
    chk(gpa_in_o == 8'h77 && gpb_in_o == 8'h88, "R2", "gpio readback",
        {gpa_in_o, gpb_in_o}, 16'h7788);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'h1111; wdata_i = 16'hFFFF;
    step();
    chk(ack_o == 1'b1 && rdata_o == 16'h0, "R3", "single-chip ack", {ack_o, rdata_o}, 32'h10000);
    chk(pa_o == 8'h5E && pa_oe_o == 8'hF0, "R3", "pins untouched", {pa_o, pa_oe_o}, 16'h5EF0);
    req_i = 1'b0;
    step();
    chk(ack_o == 1'b0, "R3", "ack one clock", 32'(ack_o), 0);
    apply_reset(2'b00);
    chk(pb_oe_o == 8'h0F && e_o == 1'b0, "R1", "mode 00 single-chip", {pb_oe_o, 7'b0, e_o}, 16'h0F00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_e_period();
    t_wide_write();
    t_wide_read();
    t_mode_held();
    t_narrow_write16();
    t_narrow_read16();
    t_narrow_byte();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule